// File: doc/BRIEF.md
# Link Delay Timing Queue

This block is the timing half of an output-buffered switch port or network interface model. A functional model hands it packet descriptors: an identifier and a length in bytes. The block holds them in a bounded queue and releases each one only after a delay. That delay is the packet's serialization time at the configured link rate, plus a fixed link latency. Packets are stored only as descriptors. The payload stays with the functional model, which forwards a packet when the block raises its release-valid output.

Link rate, link latency and buffer capacity in bytes are plain input registers, so they can change at run time. Every queued descriptor owns a down-counter. The counter is loaded on admission and advances only on a target-cycle strobe, so the model stays correct when several host cycles make up one target cycle. A packet's serialization begins only when the previous packet has left the link. Release is strictly in arrival order. Arrivals that do not fit are discarded and counted.

Top module: `pkt_delay_tm`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `drop_count` is 0.
- R2: A packet admitted to an idle link with `tick` held high raises `out_valid` exactly D target cycles after the admitting edge. D = ceil(len × cfg_cpb / 16) + cfg_lat, where `cfg_cpb` is an unsigned rate in cycles per byte with 4 fractional bits. When D = 0, `out_valid` is high right after the admitting edge.
- R3: A packet's serialization starts when the link's pending serialization time ends. With `tick` high, a packet admitted one cycle after a packet A is released at A's admitting edge + serA + its own serialization + its own latency.
- R4: Packets leave in arrival order. A later packet whose counter has reached zero stays hidden behind an unreleased head.
- R5: Counters advance only on cycles with `tick` high. With `tick` low, a waiting packet's `out_valid` does not rise. After `tick` returns, exactly the remaining D cycles elapse.
- R6: An arrival is dropped, and `drop_count` increases by 1, when the buffered byte total plus its length would exceed `cfg_cap`. A packet that fills the buffer exactly is accepted. A dropped packet never appears at the output.
- R7: An arrival is dropped, and counted, when all DEPTH descriptor slots are occupied, whatever the byte total.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_id` and `out_len` hold their values.
- R9: A release (`out_valid` and `out_ready` both high) returns that packet's length to the byte budget, so a later packet of length `cfg_cap` is accepted once the queue has drained.
- R10: The rate and latency settings apply to packets admitted after a change. Counters already loaded are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Target-cycle strobe; counters advance when high |
| cfg_cpb | input | CPB_W | Cycles per byte, 4 fractional bits |
| cfg_lat | input | LAT_W | Fixed link latency in target cycles |
| cfg_cap | input | CAP_W | Buffer capacity in bytes |
| in_valid | input | 1 | A descriptor is offered this cycle |
| in_id | input | ID_W | Packet identifier |
| in_len | input | LEN_W | Packet length in bytes |
| out_valid | output | 1 | Head packet may be forwarded |
| out_ready | input | 1 | Downstream takes the head packet |
| out_id | output | ID_W | Identifier of the head packet |
| out_len | output | LEN_W | Length of the head packet |
| drop_count | output | DROP_W | Number of discarded arrivals |

## Verification
The bench builds the block with four descriptor slots, so the slot-full drop of R7 is reached with five small arrivals. The bench sets the capacity register both to 256 KB and to 100 bytes. The small setting makes the byte-budget drop, the exact-fit acceptance and the budget return of R6 and R9 reachable with a few packets. The rate settings span zero, fractional and multi-cycle-per-byte values, so the rounding-up of R2 and the ordering of R3 and R4 are all exercised.

// File: rtl/pd_pkg.sv
package pd_pkg;
  // Number of fractional bits in the cycles-per-byte rate register.
  localparam int unsigned PD_CPB_FRAC = 4;

  // Outcome of an offered descriptor.
  typedef enum logic [1:0] {
    ADM_IDLE       = 2'd0,
    ADM_TAKE       = 2'd1,
    ADM_DROP_FULL  = 2'd2,
    ADM_DROP_BYTES = 2'd3
  } adm_e;
endpackage

// File: rtl/pd_ser_calc.sv
// Serialization time: ceil(len * rate / 2^FRAC), widened to the counter width.
module pd_ser_calc #(
  parameter int LEN_W = 16,
  parameter int CPB_W = 8,
  parameter int FRAC  = 4,
  parameter int CNT_W = 24
) (
  input  logic [LEN_W-1:0] len,
  input  logic [CPB_W-1:0] cpb,
  output logic [CNT_W-1:0] ser
);
  localparam int PROD_W = LEN_W + CPB_W;
  localparam int RND    = (1 << FRAC) - 1;

  logic [PROD_W:0] sum;
  logic [PROD_W:0] shifted;

  assign sum     = {1'b0, PROD_W'(len) * PROD_W'(cpb)} + (PROD_W+1)'(RND);
  assign shifted = sum >> FRAC;
  assign ser     = CNT_W'(shifted);
endmodule

// File: rtl/pd_link_tracker.sv
// Remaining serialization backlog of the link, so packets never overlap.
module pd_link_tracker #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             admit,
  input  logic [CNT_W-1:0] ser,
  output logic [CNT_W-1:0] base
);
  logic [CNT_W-1:0] backlog;

  // Backlog as seen after this cycle's tick.
  assign base = (tick && backlog != '0) ? backlog - 1'b1 : backlog;

  always_ff @(posedge clk) begin
    if (rst)        backlog <= '0;
    else if (admit) backlog <= base + ser;
    else            backlog <= base;
  end
endmodule

// File: rtl/pd_slot_timer.sv
// One per descriptor slot: loaded on admission, counts down on target ticks.
module pd_slot_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pkt_delay_tm.sv
module pkt_delay_tm
  import pd_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int LEN_W  = 16,
  parameter int CPB_W  = 8,
  parameter int LAT_W  = 16,
  parameter int CAP_W  = 20,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 24,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CPB_W-1:0]  cfg_cpb,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [CAP_W-1:0]  cfg_cap,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [LEN_W-1:0]  out_len,
  output logic [DROP_W-1:0] drop_count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  // Descriptor storage, no reset so it maps onto RAM.
  logic [ID_W-1:0]  id_mem  [DEPTH];
  logic [LEN_W-1:0] len_mem [DEPTH];

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;
  logic [CAP_W-1:0] bytes_used;
  logic [DEPTH-1:0] slot_zero;

  logic [CNT_W-1:0] ser, base, load_val;
  logic [CAP_W:0]   need;
  logic             fits, admit, drop, pop;
  adm_e             adm;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Admission decision
  assign need = {1'b0, bytes_used} + (CAP_W+1)'(in_len);
  assign fits = (need <= {1'b0, cfg_cap});

  always_comb begin
    if (!in_valid)                 adm = ADM_IDLE;
    else if (occ == OCC_W'(DEPTH)) adm = ADM_DROP_FULL;
    else if (!fits)                adm = ADM_DROP_BYTES;
    else                           adm = ADM_TAKE;
  end

  assign admit = (adm == ADM_TAKE);
  assign drop  = (adm == ADM_DROP_FULL) || (adm == ADM_DROP_BYTES);

  // Delay computation
  pd_ser_calc #(
    .LEN_W(LEN_W), .CPB_W(CPB_W), .FRAC(PD_CPB_FRAC), .CNT_W(CNT_W)
  ) u_ser (
    .len(in_len), .cpb(cfg_cpb), .ser(ser)
  );

  pd_link_tracker #(.CNT_W(CNT_W)) u_link (
    .clk(clk), .rst(rst), .tick(tick), .admit(admit), .ser(ser), .base(base)
  );

  assign load_val = base + ser + CNT_W'(cfg_lat);

  // Per-slot countdown timers
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    pd_slot_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .tick(tick),
      .load(admit && (wr_ptr == PTR_W'(g))),
      .load_val(load_val),
      .zero(slot_zero[g])
    );
  end

  // Head release
  assign out_valid = (occ != '0) && slot_zero[rd_ptr];
  assign out_id    = id_mem[rd_ptr];
  assign out_len   = len_mem[rd_ptr];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (admit) begin
      id_mem[wr_ptr]  <= in_id;
      len_mem[wr_ptr] <= in_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      occ        <= '0;
      bytes_used <= '0;
      drop_count <= '0;
    end else begin
      if (admit) wr_ptr <= ptr_next(wr_ptr);
      if (pop)   rd_ptr <= ptr_next(rd_ptr);
      case ({admit, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      bytes_used <= bytes_used
                  + (admit ? CAP_W'(in_len) : '0)
                  - (pop   ? CAP_W'(out_len) : '0);
      if (drop) drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/pkt_delay_tm_chk.sv
module pkt_delay_tm_chk #(
  parameter int ID_W   = 8,
  parameter int LEN_W  = 16,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              in_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ID_W-1:0]   out_id,
  input logic [LEN_W-1:0]  out_len,
  input logic [DROP_W-1:0] drop_count
);
  // R1: cleared state right after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && drop_count == '0));

  // R8: head held stable under backpressure
  p_hold_head_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_len)));

  // R5: no tick, no arrival, nothing visible -> stays invisible
  p_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick && !out_valid && !in_valid) |=> !out_valid);

  // R6: drop counter only moves after an offer
  p_drop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(drop_count));

  // R7: at most one drop per offer
  p_drop_step_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((drop_count - $past(drop_count)) <= DROP_W'(1)));
endmodule

bind pkt_delay_tm pkt_delay_tm_chk #(
  .ID_W(ID_W), .LEN_W(LEN_W), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid),
  .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
  .out_len(out_len), .drop_count(drop_count)
);

// File: tb/pkt_delay_tm_test.sv
module pkt_delay_tm_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic [7:0]  cfg_cpb = '0;
  logic [15:0] cfg_lat = '0;
  logic [19:0] cfg_cap = 20'd262144;
  logic        in_valid = 1'b0;
  logic [7:0]  in_id = '0;
  logic [15:0] in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_id;
  logic [15:0] out_len;
  logic [15:0] drop_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  pkt_delay_tm #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .tick(tick), .cfg_cpb(cfg_cpb), .cfg_lat(cfg_lat),
    .cfg_cap(cfg_cap), .in_valid(in_valid), .in_id(in_id), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .out_len(out_len), .drop_count(drop_count)
  );

  // {len[16], cpb[8], lat[16], expected delay[24]}
  localparam logic [63:0] VEC [6] = '{
    {16'd64,   8'd16,  16'd10,  24'd74},
    {16'd100,  8'd8,   16'd0,   24'd50},
    {16'd1,    8'd0,   16'd0,   24'd0},
    {16'd3,    8'd5,   16'd7,   24'd8},
    {16'd1500, 8'd128, 16'd300, 24'd12300},
    {16'd17,   8'd3,   16'd2,   24'd6}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one descriptor; returns at the falling edge after the admitting edge.
  task automatic send(input int id, input int len, input int cpb, input int lat);
    cfg_cpb  = 8'(cpb);
    cfg_lat  = 16'(lat);
    in_id    = 8'(id);
    in_len   = 16'(len);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  int got [8];
  int ng;
  task automatic collect(input int cycles);
    ng = 0;
    for (int c = 0; c < cycles; c++) begin
      if (out_valid && out_ready && ng < 8) begin
        got[ng] = int'(out_id);
        ng++;
      end
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, ta, tb, d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && drop_count == 0, "R1 reset state", out_valid, 0);
    rst = 1'b0;
    step();
    chk(!out_valid && drop_count == 0, "R1 after reset", drop_count, 0);

    // R2/R10: delay vectors with changing rate and latency
    for (int i = 0; i < 6; i++) begin
      send(i, int'(VEC[i][63:48]), int'(VEC[i][47:40]), int'(VEC[i][39:24]));
      n = 0;
      while (!out_valid && n < 20000) begin step(); n++; end
      chk(n == int'(VEC[i][23:0]), "R2 delay", n, VEC[i][23:0]);
      chk(out_id == 8'(i) && out_len == VEC[i][63:48], "R10 descriptor", out_id, i);
      step(); step();
    end

    // R5: tick gating
    tick = 1'b0;
    send(40, 4, 16, 0);
    repeat (20) step();
    chk(!out_valid, "R5 frozen without tick", out_valid, 0);
    tick = 1'b1;
    n = 0;
    while (!out_valid && n < 100) begin step(); n++; end
    chk(n == 4, "R5 remaining delay", n, 4);
    step(); step();

    // R3: back-to-back serialization
    send(30, 10, 16, 5);
    send(31, 6, 16, 5);
    ta = -1; tb = -1;
    for (int k = 1; k <= 40; k++) begin
      if (out_valid && out_id == 8'd30 && ta < 0) ta = k;
      if (out_valid && out_id == 8'd31 && tb < 0) tb = k;
      step();
    end
    chk(ta == 15, "R3 first release", ta, 15);
    chk(tb == 21, "R3 second release", tb, 21);

    // R4/R8: head blocking and hold under backpressure
    out_ready = 1'b0;
    send(50, 2, 16, 40);
    send(51, 1, 0, 0);
    n = 1;
    while (!out_valid && n < 100) begin
      if (n == 30) chk(!out_valid, "R4 later packet hidden", out_valid, 0);
      step(); n++;
    end
    chk(n == 42 && out_id == 8'd50, "R4 head first", out_id, 50);
    for (int k = 0; k < 5; k++) begin
      step();
      chk(out_valid && out_id == 8'd50 && out_len == 16'd2, "R8 hold", out_id, 50);
    end
    out_ready = 1'b1;
    step();
    chk(out_valid && out_id == 8'd51, "R4 second in order", out_id, 51);
    step();
    chk(!out_valid, "R4 drained", out_valid, 0);

    // R6/R9: byte budget
    cfg_cap = 20'd100;
    d0 = int'(drop_count);
    send(20, 60, 0, 50);
    send(21, 50, 0, 50);
    send(22, 40, 0, 50);
    chk(int'(drop_count) == d0 + 1, "R6 byte drop count", drop_count, d0 + 1);
    collect(70);
    chk(ng == 2 && got[0] == 20 && got[1] == 22, "R6 dropped packet absent", ng, 2);
    d0 = int'(drop_count);
    send(23, 100, 0, 0);
    chk(int'(drop_count) == d0, "R9 budget returned", drop_count, d0);
    collect(5);
    chk(ng == 1 && got[0] == 23, "R9 full-size packet out", ng, 1);

    // R7: slot exhaustion
    cfg_cap = 20'd262144;
    out_ready = 1'b0;
    d0 = int'(drop_count);
    for (int k = 0; k < 5; k++) send(10 + k, 1, 0, 20);
    chk(int'(drop_count) == d0 + 1, "R7 slot-full drop", drop_count, d0 + 1);
    out_ready = 1'b1;
    collect(40);
    chk(ng == 4, "R7 stored count", ng, 4);
    for (int k = 0; k < 4; k++)
      chk(got[k] == 10 + k, "R7 order", got[k], 10 + k);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule